// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is an 8-bit watchdog counter that sits on a narrow register write bus. It is guarded against stray writes: every write carries a key byte in its upper half, and a write is accepted only if that byte is the key assigned to the register it addresses. Software arms the timer by enabling it and choosing a prescale ratio. From then on it must reload the count often enough to keep the counter from wrapping. If the count passes from 0xFF to 0x00 while the timer is enabled, the block sets an overflow flag and sends a single-cycle reset request to the system reset logic.

The count clock comes from a reference strobe `ref_pulse`, one clock cycle wide, in the `clk` domain. A module-stop input `mod_stop` gates this strobe. It mirrors bit 13 of the chip's module-stop register, and the timer cannot advance until software clears that bit. Reads are registered and take one cycle.

Top module: `keyed_wdt`

## Requirements
- R1: After a synchronous reset the count, the enable, the select and the overflow flag are all zero, `rst_req` is low, and reads of both registers return 0x0000.
- R2: A write to byte offset 0x0 whose bits 15:8 equal 0x5A loads bits 7:0 into the count.
- R3: A write to byte offset 0x4 whose bits 15:8 equal 0xA5 loads bit 7 (enable) and bits 2:0 (clock select). In the same write, bit 4 written as 0 clears the overflow flag and bit 4 written as 1 leaves the flag unchanged.
- R4: A write whose key byte is not the key of the addressed register is ignored. This includes the other register's key and an unmapped offset.
- R5: While the timer is enabled and `mod_stop` is low, the count rises by one on every N-th `ref_pulse`. N is set by the select code: 0→1, 1→4, 2→16, 3→32, 4→64, 5→256, 6→1024, 7→4096.
- R6: While `mod_stop` is high, reference pulses are not counted, and the partial prescale count is held until `mod_stop` returns low.
- R7: While the timer is disabled the count does not change. Disabling the timer, or any accepted control write, restarts the prescale count from zero.
- R8: When an enabled count wraps from 0xFF to 0x00, the overflow flag (control bit 4) is set and `rst_req` is high for exactly one cycle, in the cycle after the wrapping edge.
- R9: If a count write and a prescaled tick fall on the same edge, the written value wins.
- R10: A read returns the count or the control value in bits 7:0 one cycle after `rd_addr` is presented. Bits 15:8 read as zero, control bits 6, 5 and 3 read as zero, and an unmapped offset reads as 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 3 | Byte offset of the write |
| wr_data | input | 16 | Key byte in 15:8, value in 7:0 |
| rd_addr | input | 3 | Byte offset of the read |
| rd_data | output | 16 | Registered read data |
| ref_pulse | input | 1 | Reference count strobe |
| mod_stop | input | 1 | Module-stop gate for the reference strobe, 1 = stopped |
| rst_req | output | 1 | One-cycle reset request on overflow |

## Verification
The properties assume that `ref_pulse` and `mod_stop` are synchronous to `clk` and that every write is a single-cycle `wr_en` with stable address and data. The bench drives all inputs on the falling edge and holds each write strobe for exactly one cycle, which keeps the stimulus inside these assumptions. Reference pulses are always separated by an idle cycle, so the count moves at most once per read window, and each expected count can be set by counting the pulses issued.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int SEL_W       = 3;
  localparam int EN_BIT      = 7;
  localparam int OVF_BIT     = 4;
  localparam int SHIFT_W     = 4;

  typedef struct packed {
    logic             en;
    logic             ovf;
    logic [SEL_W-1:0] sel;
  } ctl_t;

  // Prescale ratio as a power of two: 1,4,16,32,64,256,1024,4096
  function automatic logic [SHIFT_W-1:0] sel_to_shift(input logic [SEL_W-1:0] s);
    case (s)
      3'd0:    return 4'd0;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd5;
      3'd4:    return 4'd6;
      3'd5:    return 4'd8;
      3'd6:    return 4'd10;
      default: return 4'd12;
    endcase
  endfunction

  function automatic logic [7:0] ctl_image(input ctl_t c);
    logic [7:0] v;
    v            = '0;
    v[EN_BIT]    = c.en;
    v[OVF_BIT]   = c.ovf;
    v[SEL_W-1:0] = c.sel;
    return v;
  endfunction

endpackage

// File: rtl/wdt_key_decode.sv
module wdt_key_decode #(
  parameter int          ADDR_W  = 3,
  parameter int          DATA_W  = 16,
  parameter int          KEY_W   = 8,
  parameter logic [2:0]  OFF_CNT = 3'h0,
  parameter logic [2:0]  OFF_CTL = 3'h4,
  parameter logic [7:0]  KEY_CNT = 8'h5A,
  parameter logic [7:0]  KEY_CTL = 8'hA5
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cnt_we,
  output logic              ctl_we
);

  localparam int KEY_LSB = DATA_W - KEY_W;

  logic [KEY_W-1:0] key;

  always_comb begin
    key    = wr_data[DATA_W-1:KEY_LSB];
    cnt_we = wr_en && (wr_addr == ADDR_W'(OFF_CNT)) && (key == KEY_W'(KEY_CNT));
    ctl_we = wr_en && (wr_addr == ADDR_W'(OFF_CTL)) && (key == KEY_W'(KEY_CTL));
  end

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             gate_open,
  input  logic             ref_pulse,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int WIDE_W = PRE_W + 1;

  logic [PRE_W-1:0]  pre_q;
  logic [WIDE_W-1:0] span;
  logic [PRE_W-1:0]  mask;
  logic              step;

  always_comb begin
    span = (WIDE_W'(1) << sel_to_shift(sel)) - WIDE_W'(1);
    mask = span[PRE_W-1:0];
    step = en && gate_open && ref_pulse;
    tick = step && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || clr || !en) begin
      pre_q <= '0;
    end else if (step) begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (ld) begin
      cnt_q <= ld_val;
    end else if (tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    cnt  = cnt_q;
    wrap = tick && !ld && (cnt_q == {CNT_W{1'b1}});
  end

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int         ADDR_W  = 3,
  parameter int         DATA_W  = 16,
  parameter int         CNT_W   = 8,
  parameter int         PRE_W   = 12,
  parameter logic [2:0] OFF_CNT = 3'h0,
  parameter logic [2:0] OFF_CTL = 3'h4,
  parameter logic [7:0] KEY_CNT = 8'h5A,
  parameter logic [7:0] KEY_CTL = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ref_pulse,
  input  logic              mod_stop,
  output logic              rst_req
);

  logic             cnt_we;
  logic             ctl_we;
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] cnt_q;
  ctl_t             ctl_q;
  logic             rst_req_q;
  logic [DATA_W-1:0] rd_q;

  wdt_key_decode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .KEY_W  (8),
    .OFF_CNT(OFF_CNT),
    .OFF_CTL(OFF_CTL),
    .KEY_CNT(KEY_CNT),
    .KEY_CTL(KEY_CTL)
  ) u_dec (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .cnt_we (cnt_we),
    .ctl_we (ctl_we)
  );

  wdt_prescaler #(
    .PRE_W(PRE_W)
  ) u_pre (
    .clk      (clk),
    .rst      (rst),
    .en       (ctl_q.en),
    .gate_open(!mod_stop),
    .ref_pulse(ref_pulse),
    .clr      (ctl_we),
    .sel      (ctl_q.sel),
    .tick     (tick)
  );

  wdt_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .ld    (cnt_we),
    .ld_val(wr_data[CNT_W-1:0]),
    .cnt   (cnt_q),
    .wrap  (wrap)
  );

  // Control register; a wrap on the same edge always leaves the flag set
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else begin
      if (ctl_we) begin
        ctl_q.en  <= wr_data[EN_BIT];
        ctl_q.sel <= wr_data[SEL_W-1:0];
        ctl_q.ovf <= wrap || (ctl_q.ovf && wr_data[OVF_BIT]);
      end else if (wrap) begin
        ctl_q.ovf <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= wrap;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_addr == ADDR_W'(OFF_CNT)) begin
      rd_q <= DATA_W'(cnt_q);
    end else if (rd_addr == ADDR_W'(OFF_CTL)) begin
      rd_q <= DATA_W'(ctl_image(ctl_q));
    end else begin
      rd_q <= '0;
    end
  end

  assign rd_data = rd_q;
  assign rst_req = rst_req_q;

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int         ADDR_W  = 3,
  parameter int         DATA_W  = 16,
  parameter int         CNT_W   = 8,
  parameter logic [2:0] OFF_CNT = 3'h0,
  parameter logic [2:0] OFF_CTL = 3'h4,
  parameter logic [7:0] KEY_CNT = 8'h5A,
  parameter logic [7:0] KEY_CTL = 8'hA5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              mod_stop,
  input logic              rst_req,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              ctl_en,
  input logic              ctl_ovf,
  input logic [2:0]        ctl_sel,
  input logic              cnt_we
);

  // R2
  cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(OFF_CNT) && wr_data[DATA_W-1:DATA_W-8] == KEY_CNT)
    |=> cnt_q == $past(wr_data[CNT_W-1:0]));

  // R4
  bad_key_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(OFF_CTL) && wr_data[DATA_W-1:DATA_W-8] != KEY_CTL)
    |=> ($stable(ctl_en) && $stable(ctl_sel)));

  // R6
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mod_stop && !cnt_we) |=> $stable(cnt_q));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_en && !cnt_we) |=> $stable(cnt_q));

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R8
  req_flag_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (ctl_ovf && cnt_q == '0));

endmodule

bind keyed_wdt wdt_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W),
  .OFF_CNT(OFF_CNT),
  .OFF_CTL(OFF_CTL),
  .KEY_CNT(KEY_CNT),
  .KEY_CTL(KEY_CTL)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .mod_stop(mod_stop),
  .rst_req (rst_req),
  .cnt_q   (cnt_q),
  .ctl_en  (ctl_q.en),
  .ctl_ovf (ctl_q.ovf),
  .ctl_sel (ctl_q.sel),
  .cnt_we  (cnt_we)
);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        ref_pulse = 1'b0;
  logic        mod_stop = 1'b0;
  logic        rst_req;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  keyed_wdt u_keyed_wdt (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ref_pulse(ref_pulse),
    .mod_stop(mod_stop), .rst_req(rst_req)
  );

  // {addr, write data, expected count, expected control}
  localparam int NV = 10;
  localparam logic [34:0] VEC [NV] = '{
    {3'h0, 16'h5A37, 8'h37, 8'h00},  // R2 keyed count load
    {3'h0, 16'h1299, 8'h37, 8'h00},  // R4 wrong key
    {3'h0, 16'hA511, 8'h37, 8'h00},  // R4 control key at count offset
    {3'h4, 16'hA583, 8'h37, 8'h83},  // R3 enable, select 3
    {3'h4, 16'h5A00, 8'h37, 8'h83},  // R4 count key at control offset
    {3'h4, 16'hA5FF, 8'h37, 8'h87},  // R3 bit4=1 keeps clear flag, R10 zeros
    {3'h0, 16'h5AC8, 8'hC8, 8'h87},  // R2
    {3'h4, 16'hA505, 8'hC8, 8'h05},  // R3 disable
    {3'h2, 16'h5A11, 8'hC8, 8'h05},  // R4 unmapped offset
    {3'h4, 16'h0000, 8'hC8, 8'h05}   // R4 zero key
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_pulse = 1'b1;
      @(negedge clk); ref_pulse = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rst_req", {15'd0, rst_req}, 16'h0000);
    rd(3'h0, v); check("R1 count", v, 16'h0000);
    rd(3'h4, v); check("R1 control", v, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][34:32], VEC[i][31:16]);
      rd(3'h0, v); check("R2/R4 count vector", v, {8'h00, VEC[i][15:8]});
      rd(3'h4, v); check("R3/R4 control vector", v, {8'h00, VEC[i][7:0]});
    end
    rd(3'h2, v); check("R10 unmapped read", v, 16'h0000);

    // R5 prescale ratios
    for (int s = 0; s < 8; s++) begin
      case (s)
        0: n = 1;    1: n = 4;    2: n = 16;   3: n = 32;
        4: n = 64;   5: n = 256;  6: n = 1024; default: n = 4096;
      endcase
      wr(3'h4, 16'hA500);
      wr(3'h0, 16'h5A00);
      wr(3'h4, 16'hA580 | 16'(s));
      pulses(n - 1);
      rd(3'h0, v); check("R5 before tick", v, 16'h0000);
      pulses(1);
      rd(3'h0, v); check("R5 on tick", v, 16'h0001);
    end

    // R6 module stop blocks pulses
    wr(3'h4, 16'hA580);
    wr(3'h0, 16'h5A10);
    mod_stop = 1'b1;
    pulses(5);
    rd(3'h0, v); check("R6 stopped", v, 16'h0010);
    mod_stop = 1'b0;
    pulses(1);
    rd(3'h0, v); check("R6 released", v, 16'h0011);
    // R6 partial prescale held
    wr(3'h4, 16'hA581);
    pulses(2);
    mod_stop = 1'b1;
    pulses(3);
    mod_stop = 1'b0;
    pulses(1);
    rd(3'h0, v); check("R6 held partial", v, 16'h0011);
    pulses(1);
    rd(3'h0, v); check("R6 resumed tick", v, 16'h0012);

    // R7 disabled does not count; restart clears prescale
    wr(3'h4, 16'hA500);
    pulses(3);
    rd(3'h0, v); check("R7 disabled", v, 16'h0012);
    wr(3'h4, 16'hA581);
    pulses(3);
    wr(3'h4, 16'hA501);
    wr(3'h4, 16'hA581);
    pulses(3);
    rd(3'h0, v); check("R7 prescale restarted", v, 16'h0012);
    pulses(1);
    rd(3'h0, v); check("R7 tick after restart", v, 16'h0013);

    // R9 write beats tick on the same edge
    wr(3'h4, 16'hA580);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'h0; wr_data = 16'h5A40; ref_pulse = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ref_pulse = 1'b0;
    rd(3'h0, v); check("R9 write wins", v, 16'h0040);

    // R8 overflow
    wr(3'h0, 16'h5AFE);
    pulses(1);
    check("R8 no early request", {15'd0, rst_req}, 16'h0000);
    rd(3'h0, v); check("R8 count FF", v, 16'h00FF);
    pulses(1);
    check("R8 request high", {15'd0, rst_req}, 16'h0001);
    @(negedge clk);
    check("R8 request one cycle", {15'd0, rst_req}, 16'h0000);
    rd(3'h4, v); check("R8 flag set", v, 16'h0090);
    rd(3'h0, v); check("R8 count wrapped", v, 16'h0000);
    wr(3'h4, 16'hA590);
    rd(3'h4, v); check("R3 flag kept by 1", v, 16'h0090);
    wr(3'h4, 16'hA580);
    rd(3'h4, v); check("R3 flag cleared by 0", v, 16'h0080);
    // disabled at FF: no request
    wr(3'h4, 16'hA500);
    wr(3'h0, 16'h5AFF);
    pulses(1);
    check("R7 no request when disabled", {15'd0, rst_req}, 16'h0000);

    // R1 reset mid-run
    wr(3'h4, 16'hA583);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(3'h0, v); check("R1 count after reset", v, 16'h0000);
    rd(3'h4, v); check("R1 control after reset", v, 16'h0000);

    finish_run();
  end

endmodule